// File: doc/BRIEF.md
# Banked Scratchpad with Conflict Replay

This block is a fast on-chip scratchpad that serves one request from a group of 32 lanes at a time. Each lane has an active bit, a read/write flag, a byte address and a 32-bit write word. Word storage is interleaved across independent banks. Consecutive 32-bit words go to consecutive banks. Each bank can serve one word per clock. The number of banks is a parameter, 32 by default, and 16 is also supported.

When every bank is asked for at most one distinct word, the whole request is served in the cycle it is accepted. Lanes that share a word are served together. When several lanes want different words in one bank, the block replays the request. Each pass serves, in every bank, the word of the lowest-numbered lane still waiting, together with all waiting lanes that want that same word. The issuing pipeline is held by `stall` until the last pass. Each lane gets a one-cycle `done` pulse, and read lanes get their data with that pulse.

Top module: `banked_scratchpad`

## Requirements
- R1: A byte address maps to bank `(addr >> 2) mod BANKS` and to row `addr >> (2 + log2 BANKS)`. The two lowest address bits are ignored. A word written at an address is returned by a later read of that address, and other addresses keep their contents.
- R2: A request in which no bank sees two distinct words among active lanes is served in one pass. `done` is high for every active lane in the cycle after acceptance, and `stall` stays low.
- R3: Active lanes that address the same word are served in the same pass, so a word shared by any number of lanes costs one pass.
- R4: The number of passes equals the largest number of distinct words requested in any single bank. `stall` is high for exactly that number minus one cycles, starting the cycle after acceptance.
- R5: In each pass, every bank serves the word of its lowest-numbered waiting lane. Pass k (counting from 0) raises `done` for its lanes k+1 cycles after the accepting edge, with `rdata` valid in that same cycle.
- R6: When several lanes write the same word in one request, the highest-numbered lane's data is stored.
- R7: Inactive lanes never receive `done`, take no part in conflict counting, and write nothing.
- R8: `req_valid` is accepted only on an edge where `stall` is low. A request presented while `stall` is high has no effect.
- R9: A read served in the same pass as a write to the same word returns the word's value from before that write.
- R10: Each active lane of an accepted request receives exactly one `done` pulse.
- R11: With BANKS = 16, addresses 64 bytes apart share a bank and conflict, whereas with 32 banks they do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_active | input | LANES | Per-lane participation bit |
| req_write | input | LANES | Per-lane write (1) or read (0) |
| req_addr | input | LANES*AW | Per-lane byte address, lane l at bits l*AW upward |
| req_wdata | input | LANES*32 | Per-lane write word |
| stall | output | 1 | Replay in progress; new requests are refused |
| done | output | LANES | One-cycle completion pulse per lane |
| rdata | output | LANES*32 | Per-lane read word, valid with `done` |

## Verification
For a lane served in pass k, `done` and read data are due k+1 rising edges after the accepting edge. `stall` is due in cycles 1 through K-1, where K is the number of passes. The bench drives stimulus on falling edges and samples on every following falling edge. It records the cycle index at which each lane's `done` appears, so every result is compared against the exact cycle the requirements fix. Stored contents are checked only by later read requests through the normal ports.

// File: rtl/banked_scratchpad.sv
`timescale 1ns/1ps
module banked_scratchpad #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int DEPTH = 16,
  localparam int DW = 32,
  localparam int AW = 2 + $clog2(BANKS) + $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES-1:0]    req_write,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                stall,
  output logic [LANES-1:0]    done,
  output logic [LANES*DW-1:0] rdata
);
  localparam int BB = $clog2(BANKS);
  localparam int RB = $clog2(DEPTH);

  logic [LANES-1:0]    pend_q, wr_q, done_q;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*DW-1:0] wd_q;
  logic                accept;

  logic [LANES-1:0]    pend, wr_s, first, grant;
  logic [LANES*AW-1:0] addr_s;
  logic [LANES*DW-1:0] wd_s;
  logic [BB-1:0]       lbank [LANES];
  logic [RB-1:0]       lrow  [LANES];
  logic [BB-1:0]       lbank_q [LANES];
  logic [DW-1:0]       bank_rd [BANKS];
  logic [LANES*2-1:0]  lo_unused;

  assign stall  = |pend_q;
  assign accept = req_valid && !stall;
  assign pend   = stall ? pend_q : (accept ? req_active : '0);
  assign wr_s   = stall ? wr_q   : req_write;
  assign addr_s = stall ? addr_q : req_addr;
  assign wd_s   = stall ? wd_q   : req_wdata;
  assign done   = done_q;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      lbank[l]              = addr_s[l*AW+2 +: BB];
      lrow[l]               = addr_s[l*AW+2+BB +: RB];
      lo_unused[l*2 +: 2]   = addr_s[l*AW +: 2];
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      first[l] = pend[l];
      for (int j = 0; j < LANES; j++)
        if (j < l && pend[j] && lbank[j] == lbank[l]) first[l] = 1'b0;
    end
    for (int l = 0; l < LANES; l++) begin
      grant[l] = 1'b0;
      for (int j = 0; j < LANES; j++)
        if (j <= l && first[j] && pend[l] && lbank[j] == lbank[l] && lrow[j] == lrow[l])
          grant[l] = 1'b1;
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;
    logic          bact, bwe;
    logic [RB-1:0] brow;
    logic [DW-1:0] bwd;

    always_comb begin
      bact = 1'b0;
      bwe  = 1'b0;
      brow = '0;
      bwd  = '0;
      for (int l = 0; l < LANES; l++) begin
        if (grant[l] && lbank[l] == BB'(b)) begin
          bact = 1'b1;
          brow = lrow[l];
          if (wr_s[l]) begin
            bwe = 1'b1;
            bwd = wd_s[l*DW +: DW];
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (bact) rd_q <= mem[brow];
      if (bwe)  mem[brow] <= bwd;
    end

    assign bank_rd[b] = rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      done_q <= '0;
    end else begin
      pend_q <= pend & ~grant;
      done_q <= grant;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q <= req_addr;
      wr_q   <= req_write;
      wd_q   <= req_wdata;
    end
    for (int l = 0; l < LANES; l++) lbank_q[l] <= lbank[l];
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) rdata[l*DW +: DW] = bank_rd[lbank_q[l]];
  end
endmodule

module banked_scratchpad_chk #(
  parameter int LANES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LANES-1:0] req_active,
  input logic             stall,
  input logic [LANES-1:0] done
);
  logic [LANES-1:0] owed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= (owed_q & ~done) | ((req_valid && !stall) ? req_active : '0);
  end

  assert_done_owed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done & ~owed_q) == '0);

  assert_stall_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (owed_q & ~done) != '0);

  assert_last_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> done == owed_q);

  assert_pass_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> done != '0);
endmodule

bind banked_scratchpad banked_scratchpad_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_active(req_active),
  .stall(stall), .done(done)
);

// File: tb/test_banked_scratchpad.sv
`timescale 1ns/1ps
module test_banked_scratchpad;
  localparam int L = 32;
  localparam int AW = 11;
  localparam int AW16 = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, v16 = 1'b0;
  logic [L-1:0] act = '0, wr = '0;
  logic [10:0] lane_addr [L];
  logic [31:0] lane_wd [L];
  logic [L*AW-1:0] addr_bus;
  logic [L*AW16-1:0] addr16;
  logic [L*32-1:0] wd_bus;
  logic stall, stall16;
  logic [L-1:0] done, done16;
  logic [L*32-1:0] rdata, rdata16;

  int n_chk = 0, n_fail = 0;
  int got_cyc [L];
  int got_cnt [L];
  logic [31:0] got_dat [L];
  int n_stall;
  logic [31:0] model [0:511];

  always #2.5 clk = ~clk;

  always_comb begin
    for (int l = 0; l < L; l++) begin
      addr_bus[l*AW +: AW]     = lane_addr[l];
      addr16[l*AW16 +: AW16]   = lane_addr[l][9:0];
      wd_bus[l*32 +: 32]       = lane_wd[l];
    end
  end

  banked_scratchpad i_banked_scratchpad (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_active(act), .req_write(wr),
    .req_addr(addr_bus), .req_wdata(wd_bus), .stall(stall), .done(done), .rdata(rdata));

  banked_scratchpad #(.BANKS(16)) i_banked_scratchpad_b16 (
    .clk(clk), .rst_n(rst_n), .req_valid(v16), .req_active(act), .req_write(wr),
    .req_addr(addr16), .req_wdata(wd_bus), .stall(stall16), .done(done16), .rdata(rdata16));

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] actv, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, actv, expv);
    end
  endtask

  task automatic clear_lanes();
    act = '0;
    wr = '0;
    for (int l = 0; l < L; l++) begin
      lane_addr[l] = '0;
      lane_wd[l] = '0;
    end
  endtask

  task automatic set_lane(input int l, input bit w, input int a, input logic [31:0] d);
    act[l] = 1'b1;
    wr[l] = w;
    lane_addr[l] = 11'(a);
    lane_wd[l] = d;
  endtask

  task automatic commit_writes();
    for (int l = 0; l < L; l++)
      if (act[l] && wr[l]) model[lane_addr[l] >> 2] = lane_wd[l];
  endtask

  task automatic run_req();
    for (int l = 0; l < L; l++) begin
      got_cyc[l] = 0;
      got_cnt[l] = 0;
      got_dat[l] = '0;
    end
    n_stall = 0;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c <= 40; c++) begin
      for (int l = 0; l < L; l++)
        if (done[l]) begin
          got_cnt[l]++;
          got_cyc[l] = c;
          got_dat[l] = rdata[l*32 +: 32];
        end
      if (!stall) break;
      n_stall++;
      @(negedge clk);
    end
  endtask

  function automatic int exp_passes(input int nb);
    int best;
    logic [31:0] seen;
    best = 0;
    for (int b = 0; b < nb; b++) begin
      seen = '0;
      for (int l = 0; l < L; l++)
        if (act[l] && ((lane_addr[l] >> 2) % nb) == b) seen[(lane_addr[l] >> 2) / nb] = 1'b1;
      if ($countones(seen) > best) best = $countones(seen);
    end
    return best;
  endfunction

  task automatic check_all_done_once(input string rq);
    for (int l = 0; l < L; l++)
      chk(got_cnt[l] == (act[l] ? 1 : 0), rq, $sformatf("done count lane %0d", l),
          32'(got_cnt[l]), act[l] ? 32'd1 : 32'd0);
  endtask

  task automatic t_reset();
    chk(stall == 1'b0, "R8", "stall after reset", 32'(stall), 0);
    chk(done == '0, "R10", "done after reset", done, 0);
  endtask

  task automatic t_conflict_free();
    clear_lanes();
    for (int l = 0; l < L; l++) set_lane(l, 1'b1, 4*l, 32'hA000 + l);
    run_req();
    commit_writes();
    chk(n_stall == 0, "R2", "stall cycles full write", 32'(n_stall), 0);
    for (int l = 0; l < L; l++)
      chk(got_cyc[l] == 1, "R2", $sformatf("done cycle lane %0d", l), 32'(got_cyc[l]), 1);
    clear_lanes();
    for (int l = 0; l < L; l++) set_lane(l, 1'b0, 4*((l+5) % L), 0);
    run_req();
    chk(n_stall == 0, "R2", "stall cycles rotated read", 32'(n_stall), 0);
    for (int l = 0; l < L; l++)
      chk(got_dat[l] == model[(l+5) % L], "R1", $sformatf("read lane %0d", l),
          got_dat[l], model[(l+5) % L]);
  endtask

  task automatic t_broadcast();
    clear_lanes();
    for (int l = 0; l < L; l++) set_lane(l, 1'b0, 12, 0);
    run_req();
    chk(n_stall == 0, "R3", "broadcast stall cycles", 32'(n_stall), 0);
    for (int l = 0; l < L; l++)
      chk(got_cyc[l] == 1 && got_dat[l] == model[3], "R3", $sformatf("broadcast lane %0d", l),
          got_dat[l], model[3]);
  endtask

  task automatic t_serialize();
    clear_lanes();
    for (int r = 0; r < 4; r++) set_lane(r, 1'b1, 128*r, 32'hB00 + r);
    run_req();
    commit_writes();
    chk(n_stall == 3, "R4", "stall cycles 4-way write", 32'(n_stall), 3);
    for (int r = 0; r < 4; r++)
      chk(got_cyc[r] == r + 1, "R5", $sformatf("write pass lane %0d", r), 32'(got_cyc[r]), 32'(r + 1));
    clear_lanes();
    for (int r = 0; r < 4; r++) set_lane(r, 1'b0, 128*(3-r), 0);
    set_lane(4, 1'b0, 128*3, 0);
    run_req();
    chk(n_stall == 3, "R4", "stall cycles 4-way read", 32'(n_stall), 3);
    for (int r = 0; r < 4; r++) begin
      chk(got_cyc[r] == r + 1, "R5", $sformatf("read pass lane %0d", r), 32'(got_cyc[r]), 32'(r + 1));
      chk(got_dat[r] == model[32*(3-r)], "R5", $sformatf("read data lane %0d", r),
          got_dat[r], model[32*(3-r)]);
    end
    chk(got_cyc[4] == 1 && got_dat[4] == model[96], "R3", "shared word rides first pass",
        32'(got_cyc[4]), 1);
    check_all_done_once("R10");
  endtask

  task automatic t_inactive();
    clear_lanes();
    set_lane(0, 1'b1, 128*6, 32'h77);
    run_req();
    commit_writes();
    clear_lanes();
    set_lane(1, 1'b1, 128*5, 32'h55);
    set_lane(2, 1'b1, 128*6, 32'h99);
    act[2] = 1'b0;
    run_req();
    commit_writes();
    chk(n_stall == 0, "R7", "inactive lane causes no replay", 32'(n_stall), 0);
    chk(got_cnt[2] == 0, "R7", "no done on inactive lane", 32'(got_cnt[2]), 0);
    chk(got_cyc[1] == 1, "R7", "active lane single pass", 32'(got_cyc[1]), 1);
    clear_lanes();
    set_lane(0, 1'b0, 128*6, 0);
    set_lane(1, 1'b0, 128*5, 0);
    run_req();
    chk(got_dat[0] == 32'h77, "R7", "inactive write stored nothing", got_dat[0], 32'h77);
    chk(got_dat[1] == 32'h55, "R1", "active write stored", got_dat[1], 32'h55);
  endtask

  task automatic t_write_merge();
    logic [31:0] old;
    old = model[2];
    clear_lanes();
    set_lane(3, 1'b1, 8, 32'hC3);
    set_lane(9, 1'b1, 8, 32'hC9);
    set_lane(5, 1'b0, 8, 0);
    run_req();
    commit_writes();
    chk(n_stall == 0, "R6", "same-word writes in one pass", 32'(n_stall), 0);
    chk(got_dat[5] == old, "R9", "read sees pre-write value", got_dat[5], old);
    clear_lanes();
    set_lane(0, 1'b0, 8, 0);
    run_req();
    chk(got_dat[0] == 32'hC9, "R6", "highest lane write wins", got_dat[0], 32'hC9);
  endtask

  task automatic t_stall_ignore();
    clear_lanes();
    set_lane(0, 1'b1, 16, 32'hE0);
    set_lane(1, 1'b1, 128 + 16, 32'hE1);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(stall == 1'b1, "R4", "stall during second pass", 32'(stall), 1);
    chk(done == 32'h1, "R5", "first pass done mask", done, 32'h1);
    commit_writes();
    clear_lanes();
    set_lane(7, 1'b1, 28, 32'hDEAD);
    @(negedge clk);
    req_valid = 1'b0;
    chk(stall == 1'b0, "R8", "stall released", 32'(stall), 0);
    chk(done == 32'h2, "R8", "only old request completes", done, 32'h2);
    @(negedge clk);
    chk(done == '0, "R8", "refused request never completes", done, 0);
    clear_lanes();
    set_lane(0, 1'b0, 28, 0);
    run_req();
    chk(got_dat[0] == model[7], "R8", "refused write left memory", got_dat[0], model[7]);
  endtask

  task automatic t_pattern();
    int ep;
    clear_lanes();
    for (int l = 0; l < L; l++) set_lane(l, 1'b1, 4*((l*7) % 4) + 128*((l*5) % 16), 32'h5000 + l);
    ep = exp_passes(32);
    run_req();
    commit_writes();
    chk(n_stall == ep - 1, "R4", "pattern write stall cycles", 32'(n_stall), 32'(ep - 1));
    check_all_done_once("R10");
    for (int l = 0; l < L; l++) wr[l] = 1'b0;
    run_req();
    chk(n_stall == ep - 1, "R4", "pattern read stall cycles", 32'(n_stall), 32'(ep - 1));
    for (int l = 0; l < L; l++)
      chk(got_dat[l] == model[lane_addr[l] >> 2], "R6", $sformatf("pattern read lane %0d", l),
          got_dat[l], model[lane_addr[l] >> 2]);
  endtask

  task automatic t_sixteen_banks();
    clear_lanes();
    set_lane(0, 1'b1, 0, 32'h61);
    set_lane(1, 1'b1, 64, 32'h62);
    chk(exp_passes(16) == 2, "R11", "bench model passes", 32'(exp_passes(16)), 2);
    run_req();
    commit_writes();
    chk(n_stall == 0 && got_cyc[1] == 1, "R1", "32 banks: 64 bytes apart no conflict",
        32'(n_stall), 0);
    v16 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    v16 = 1'b0;
    chk(stall16 == 1'b1 && done16 == 32'h1, "R11", "16 banks first pass", done16, 32'h1);
    @(negedge clk);
    chk(stall16 == 1'b0 && done16 == 32'h2, "R11", "16 banks second pass", done16, 32'h2);
    clear_lanes();
    set_lane(0, 1'b0, 64, 0);
    v16 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    v16 = 1'b0;
    chk(rdata16[31:0] == 32'h62, "R11", "16 banks read back", rdata16[31:0], 32'h62);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) model[i] = '0;
    clear_lanes();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_conflict_free();
    t_broadcast();
    t_serialize();
    t_inactive();
    t_write_merge();
    t_stall_ignore();
    t_pattern();
    t_sixteen_banks();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule